// File: doc/BRIEF.md
# Device Interrupt Routing Hub

This block sits between a fixed set of device interrupt lines and the processors of a chip. Every source owns a routing register, which names a target processor and an interrupt vector, and a control register, which holds a mask bit and a pending flag. When a line fires on a source that is unmasked, the hub sends that source's vector to that source's processor on a single post port. It then masks the source and marks it pending, so software must clear pending and unmask the source before the next delivery. An interrupt on a masked source is discarded.

Software reaches the registers through a 64-bit read/write port with an 8-byte register stride. The same port exposes a dispatch register. A write to it sends an interprocessor interrupt, but only for type code 0. A small register holds the vector used for bus-originated interrupts. Requests that arrive together are served one per cycle, lowest source first. A dispatch that posts in a given cycle takes the post port ahead of any device.

Top module: `irq_route_hub`

## Requirements
- R1: After reset every source reads back processor 0, vector 0, mask set (control value 4) and pending clear, and the post port is idle.
- R2: The routing register of source i sits at offset 8*i. A write keeps bits 12:8 as the processor and bits 5:0 as the vector. A read returns those fields at the same positions and zero in every other bit.
- R3: The control register of source i sits at offset 0x200 + 8*i. Bit 2 reads and writes the mask and bit 0 reads the pending flag. A write with bit 1 set clears pending, and a write with bit 1 clear leaves pending as it was.
- R4: A device interrupt on a masked source produces no post and leaves that source's registers unchanged.
- R5: A device interrupt on an unmasked source, presented in one cycle, produces a one-cycle post_valid pulse at the next clock edge carrying the source's processor and vector. The same edge sets both mask and pending for that source.
- R6: When several unmasked sources fire together, their posts leave one per cycle on consecutive cycles in ascending source order.
- R7: A write to the dispatch register at offset 0x600 takes its type from bits 17:16, the processor from bits 12:8 and the vector from bits 5:0. Type 0 posts these at the next edge, and types 1 to 3 post nothing.
- R8: A type-0 dispatch write and a device interrupt in the same cycle post the dispatch first and the device on the following cycle.
- R9: The bus interrupt vector register at offset 0x400 stores bits 5:0 of a write and reads back only those six bits.
- R10: Some offsets are unmapped: a source index at or above NUM_SRC, nonzero low three bits, nonzero bits 8:0 in the 0x400 and 0x600 banks, or bank bits 11:9 above 3. Such an access reads zero, leaves all state unchanged on a write, and raises reg_err for one cycle alongside the response. A read of the dispatch register returns zero with no error.
- R11: A read request returns its data with a one-cycle reg_rvalid pulse at the clock edge after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access request, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response pulse |
| reg_err | output | 1 | Unmapped-offset pulse |
| dev_irq | input | NUM_SRC | Device interrupt lines, one per source |
| post_valid | output | 1 | Interrupt post pulse |
| post_cpu | output | 5 | Target processor of the post |
| post_vec | output | 6 | Vector of the post |

## Verification
The checker assumes that register requests last one cycle each. It also assumes that a dispatch write can take the post port from device service without losing the device request. The stimulus drives every access as a single-cycle request with idle cycles around it. After each burst of interrupts it waits until every held request has drained before the next access, so a held request never meets a software write to its own source. Random traffic stays on mapped offsets. Unmapped and colliding cases come only from directed steps whose outcome is computed separately.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned DATA_W  = 64;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned CPU_W   = 5;
    localparam int unsigned VEC_W   = 6;
    localparam int unsigned IDX_W   = 6;

    // bank select in address bits 11:9
    localparam logic [2:0] BANK_ROUTE = 3'd0;
    localparam logic [2:0] BANK_CTRL  = 3'd1;
    localparam logic [2:0] BANK_BVEC  = 3'd2;
    localparam logic [2:0] BANK_DISP  = 3'd3;

    // control register bit positions
    localparam int unsigned MASK_BIT = 2;
    localparam int unsigned CLR_BIT  = 1;

    typedef struct packed {
        logic [CPU_W-1:0] cpu;
        logic [VEC_W-1:0] vec;
    } route_t;

    typedef struct packed {
        logic mask;
        logic pend;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ROUTE,
        SEL_CTRL,
        SEL_BVEC,
        SEL_DISP
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] idx;
        logic             bad;
    } dec_t;

    function automatic route_t route_from_word(input logic [DATA_W-1:0] w);
        route_t r;
        r.cpu = w[12:8];
        r.vec = w[5:0];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] route_to_word(input route_t r);
        return {51'b0, r.cpu, 2'b00, r.vec};
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        return {61'b0, c.mask, 1'b0, c.pend};
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [IDX_W:0] SRC_LIM = (IDX_W+1)'(NUM_SRC);

    logic [2:0]       bank;
    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             in_range;
    logic             base_only;

    assign bank      = addr[11:9];
    assign idx       = addr[8:3];
    assign aligned   = (addr[2:0] == 3'b000);
    assign in_range  = ({1'b0, idx} < SRC_LIM);
    assign base_only = (addr[8:0] == 9'd0);

    always_comb begin
        dec.sel = SEL_NONE;
        dec.idx = idx;
        dec.bad = 1'b0;
        unique case (bank)
            BANK_ROUTE: if (aligned && in_range) dec.sel = SEL_ROUTE; else dec.bad = 1'b1;
            BANK_CTRL:  if (aligned && in_range) dec.sel = SEL_CTRL;  else dec.bad = 1'b1;
            BANK_BVEC:  if (base_only) dec.sel = SEL_BVEC; else dec.bad = 1'b1;
            BANK_DISP:  if (base_only) dec.sel = SEL_DISP; else dec.bad = 1'b1;
            default:    dec.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/irq_route_pick.sv
module irq_route_pick #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            grant[i] = req[i] & ~taken;
            taken    = taken | req[i];
        end
    end
endmodule

// File: rtl/irq_route_slot.sv
module irq_route_slot
    import irq_route_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_route,
    input  route_t route_in,
    input  logic   wr_ctrl,
    input  logic   mask_in,
    input  logic   clr_in,
    input  logic   serve,
    output route_t route,
    output ctrl_t  ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            route     <= '0;
            ctrl.mask <= 1'b1;
            ctrl.pend <= 1'b0;
        end else begin
            if (wr_route) route <= route_in;
            if (wr_ctrl) begin
                ctrl.mask <= mask_in;
                if (clr_in) ctrl.pend <= 1'b0;
            end
            // delivery overrides a same-cycle software write
            if (serve) begin
                ctrl.mask <= 1'b1;
                ctrl.pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_en,
    input  logic               reg_we,
    input  logic [11:0]        reg_addr,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    output logic               reg_rvalid,
    output logic               reg_err,
    input  logic [NUM_SRC-1:0] dev_irq,
    output logic               post_valid,
    output logic [4:0]         post_cpu,
    output logic [5:0]         post_vec
);
    dec_t               dec;
    logic               wr;
    logic               rd;
    logic               disp_fire;
    route_t             route [NUM_SRC];
    ctrl_t              ctrl  [NUM_SRC];
    logic [NUM_SRC-1:0] mask_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] held_q;
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] cand;
    logic [NUM_SRC-1:0] serve_oh;
    logic [VEC_W-1:0]   bvec_q;
    route_t             served;
    logic [DATA_W-1:0]  rd_word;

    irq_route_decode #(.NUM_SRC(NUM_SRC)) u_dec (
        .addr (reg_addr),
        .dec  (dec)
    );

    assign wr        = reg_en & reg_we;
    assign rd        = reg_en & ~reg_we;
    assign disp_fire = wr && (dec.sel == SEL_DISP) && (reg_wdata[17:16] == 2'b00);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        logic hit;
        assign hit = (dec.idx == IDX_W'(g));
        irq_route_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_route (wr && hit && (dec.sel == SEL_ROUTE)),
            .route_in (route_from_word(reg_wdata)),
            .wr_ctrl  (wr && hit && (dec.sel == SEL_CTRL)),
            .mask_in  (reg_wdata[MASK_BIT]),
            .clr_in   (reg_wdata[CLR_BIT]),
            .serve    (serve_oh[g]),
            .route    (route[g]),
            .ctrl     (ctrl[g])
        );
        assign mask_vec[g] = ctrl[g].mask;
        assign pend_vec[g] = ctrl[g].pend;
    end

    // requests on masked sources fall away; a dispatch post blocks service
    assign live = (held_q | dev_irq) & ~mask_vec;
    assign cand = disp_fire ? '0 : live;

    irq_route_pick #(.N(NUM_SRC)) u_pick (
        .req   (cand),
        .grant (serve_oh)
    );

    always_comb begin
        served = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (serve_oh[i]) served = served | route[i];
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (dec.sel)
            SEL_ROUTE: for (int i = 0; i < NUM_SRC; i++)
                           if (dec.idx == IDX_W'(i)) rd_word = route_to_word(route[i]);
            SEL_CTRL:  for (int i = 0; i < NUM_SRC; i++)
                           if (dec.idx == IDX_W'(i)) rd_word = ctrl_to_word(ctrl[i]);
            SEL_BVEC:  rd_word = {{(DATA_W-VEC_W){1'b0}}, bvec_q};
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q     <= '0;
            bvec_q     <= '0;
            post_valid <= 1'b0;
            post_cpu   <= '0;
            post_vec   <= '0;
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
            reg_err    <= 1'b0;
        end else begin
            held_q     <= live & ~serve_oh;
            if (wr && dec.sel == SEL_BVEC) bvec_q <= reg_wdata[VEC_W-1:0];
            post_valid <= disp_fire | (|serve_oh);
            post_cpu   <= disp_fire ? reg_wdata[12:8] : served.cpu;
            post_vec   <= disp_fire ? reg_wdata[5:0]  : served.vec;
            reg_rvalid <= rd;
            reg_rdata  <= rd ? rd_word : '0;
            reg_err    <= reg_en & dec.bad;
        end
    end
endmodule

// File: rtl/irq_route_hub_chk.sv
module irq_route_hub_chk #(
    parameter int unsigned NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_en,
    input logic               reg_we,
    input logic [11:0]        reg_addr,
    input logic [63:0]        reg_wdata,
    input logic [63:0]        reg_rdata,
    input logic               reg_rvalid,
    input logic               reg_err,
    input logic               post_valid,
    input logic [NUM_SRC-1:0] serve_oh,
    input logic [NUM_SRC-1:0] mask_vec,
    input logic [NUM_SRC-1:0] pend_vec
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_vec == '1 && pend_vec == '0 && !post_valid));

    // R4
    masked_no_serve_chk: assert property (@(posedge clk) disable iff (rst)
        (serve_oh & mask_vec) == '0);

    // R6
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(serve_oh));

    // R5
    serve_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (serve_oh != '0) |=> (post_valid &&
            ((mask_vec & pend_vec & $past(serve_oh)) == $past(serve_oh))));

    // R8
    disp_first_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_en && reg_we && reg_addr == 12'h600 && reg_wdata[17:16] == 2'b00)
            |-> (serve_oh == '0));

    // R11
    rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rvalid |-> $past(reg_en && !reg_we));

    // R10
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_err && reg_rvalid) |-> (reg_rdata == '0));

    // R10
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        reg_err |-> $past(reg_en));
endmodule

bind irq_route_hub irq_route_hub_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .reg_err    (reg_err),
    .post_valid (post_valid),
    .serve_oh   (serve_oh),
    .mask_vec   (mask_vec),
    .pend_vec   (pend_vec)
);

// File: tb/irq_route_hub_bench.sv
module irq_route_hub_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_en = 1'b0;
    logic            reg_we = 1'b0;
    logic [11:0]     reg_addr = '0;
    logic [63:0]     reg_wdata = '0;
    logic [63:0]     reg_rdata;
    logic            reg_rvalid;
    logic            reg_err;
    logic [NSRC-1:0] dev_irq = '0;
    logic            post_valid;
    logic [4:0]      post_cpu;
    logic [5:0]      post_vec;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [10:0] postq [$];
    int          postc [$];
    logic [10:0] expq  [$];

    logic [4:0] m_cpu  [NSRC];
    logic [5:0] m_vec  [NSRC];
    logic       m_mask [NSRC];
    logic       m_pend [NSRC];
    logic [5:0] m_bvec;

    irq_route_hub #(.NUM_SRC(NSRC)) u_irq_route_hub (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .reg_err(reg_err), .dev_irq(dev_irq),
        .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst && post_valid) begin
            postq.push_back({post_cpu, post_vec});
            postc.push_back(cyc);
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_err(input logic [11:0] a);
        case (a[11:9])
            3'd0, 3'd1: return !(a[2:0] == 3'b000 && a[8:3] < NSRC);
            3'd2, 3'd3: return a[8:0] != 9'd0;
            default:    return 1'b1;
        endcase
    endfunction

    function automatic logic [63:0] exp_read(input logic [11:0] a);
        if (exp_err(a)) return 64'd0;
        case (a[11:9])
            3'd0:    return 64'({m_cpu[a[5:3]], 8'd0} | {8'd0, m_vec[a[5:3]]});
            3'd1:    return 64'({m_mask[a[5:3]], 1'b0, m_pend[a[5:3]]});
            3'd2:    return 64'(m_bvec);
            default: return 64'd0;
        endcase
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [63:0] d);
        if (exp_err(a)) return;
        case (a[11:9])
            3'd0: begin m_cpu[a[5:3]] = d[12:8]; m_vec[a[5:3]] = d[5:0]; end
            3'd1: begin m_mask[a[5:3]] = d[2]; if (d[1]) m_pend[a[5:3]] = 1'b0; end
            3'd2: m_bvec = d[5:0];
            default: ;
        endcase
    endfunction

    task automatic reg_wr(input logic [11:0] a, input logic [63:0] d, input string req);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        check(reg_err == exp_err(a), req, 64'(reg_err), 64'(exp_err(a)));
        model_write(a, d);
    endtask

    task automatic reg_rd(input logic [11:0] a, input string req);
        logic [63:0] e;
        e = exp_read(a);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        check(reg_rvalid == 1'b1, "R11", 64'(reg_rvalid), 64'd1);
        check(reg_rdata == e, req, reg_rdata, e);
        check(reg_err == exp_err(a), "R10", 64'(reg_err), 64'(exp_err(a)));
        @(negedge clk);
        check(reg_rvalid == 1'b0 && reg_err == 1'b0, "R11", 64'({reg_rvalid, reg_err}), 64'd0);
    endtask

    task automatic compare_posts(input string req, input bit consecutive);
        #1;
        check(postq.size() == expq.size(), req, 64'(postq.size()), 64'(expq.size()));
        for (int i = 0; i < expq.size() && i < postq.size(); i++)
            check(postq[i] == expq[i], req, 64'(postq[i]), 64'(expq[i]));
        if (consecutive)
            for (int i = 1; i < postc.size(); i++)
                check(postc[i] == postc[i-1] + 1, req, 64'(postc[i] - postc[i-1]), 64'd1);
        postq.delete(); postc.delete(); expq.delete();
    endtask

    task automatic fire(input logic [NSRC-1:0] bits, input string req);
        for (int i = 0; i < NSRC; i++) begin
            if (bits[i] && !m_mask[i]) begin
                expq.push_back({m_cpu[i], m_vec[i]});
                m_mask[i] = 1'b1; m_pend[i] = 1'b1;
            end
        end
        @(negedge clk);
        dev_irq = bits;
        @(negedge clk);
        dev_irq = '0;
        repeat (NSRC + 2) @(negedge clk);
        compare_posts(req, 1'b1);
    endtask

    task automatic dispatch(input logic [1:0] t, input logic [4:0] c, input logic [5:0] v, input string req);
        if (t == 2'd0) expq.push_back({c, v});
        reg_wr(12'h600, {46'd0, t, 3'd0, c, 2'd0, v}, req);
        repeat (2) @(negedge clk);
        compare_posts(req, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < NSRC; i++) begin
            m_cpu[i] = '0; m_vec[i] = '0; m_mask[i] = 1'b1; m_pend[i] = 1'b0;
        end
        m_bvec = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values and idle post port
        for (int i = 0; i < NSRC; i++) begin
            reg_rd(12'(8*i), "R1");
            reg_rd(12'h200 + 12'(8*i), "R1");
        end
        compare_posts("R1", 1'b0);

        // R2 field placement with junk in unused bits
        reg_wr(12'h018, 64'hFFFF_0000_0000_F5EA, "R2");
        reg_rd(12'h018, "R2");
        check(exp_read(12'h018) == 64'h152A, "R2", exp_read(12'h018), 64'h152A);

        // R5 delivery then R3 pending handling
        reg_wr(12'h218, 64'h0, "R3");
        fire(8'b0000_1000, "R5");
        reg_rd(12'h218, "R5");
        reg_wr(12'h218, 64'h0, "R3");
        reg_rd(12'h218, "R3");
        reg_wr(12'h218, 64'h2, "R3");
        reg_rd(12'h218, "R3");

        // R4 masked source drops
        reg_wr(12'h028, 64'h0000_0A11, "R4");
        fire(8'b0010_0000, "R4");
        reg_rd(12'h228, "R4");
        reg_rd(12'h028, "R4");

        // R6 simultaneous sources, source 0 masked
        reg_wr(12'h008, 64'h0000_0101, "R6");
        reg_wr(12'h010, 64'h0000_0202, "R6");
        reg_wr(12'h030, 64'h0000_0606, "R6");
        reg_wr(12'h208, 64'h0, "R6");
        reg_wr(12'h210, 64'h0, "R6");
        reg_wr(12'h230, 64'h0, "R6");
        fire(8'b0100_0111, "R6");

        // R7 dispatch types
        dispatch(2'd0, 5'd19, 6'd33, "R7");
        dispatch(2'd1, 5'd3, 6'd4, "R7");
        dispatch(2'd2, 5'd3, 6'd4, "R7");
        dispatch(2'd3, 5'd3, 6'd4, "R7");
        reg_rd(12'h600, "R10");

        // R8 dispatch and device in the same cycle
        reg_wr(12'h020, 64'h0000_0C2C, "R8");
        reg_wr(12'h220, 64'h0, "R8");
        expq.push_back({5'd7, 6'd9});
        expq.push_back({5'd12, 6'd44});
        m_mask[4] = 1'b1; m_pend[4] = 1'b1;
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 12'h600; reg_wdata = 64'h0709;
        dev_irq = 8'b0001_0000;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; dev_irq = '0;
        repeat (3) @(negedge clk);
        compare_posts("R8", 1'b1);
        reg_rd(12'h220, "R8");

        // R9 bus vector register
        reg_wr(12'h400, 64'hFFFF_FFFF_FFFF_FFC5, "R9");
        reg_rd(12'h400, "R9");

        // R10 unmapped offsets
        reg_rd(12'h040, "R10");
        reg_rd(12'h003, "R10");
        reg_rd(12'hA00, "R10");
        reg_rd(12'h240, "R10");
        reg_wr(12'h404, 64'h3F, "R10");
        reg_wr(12'h041, 64'h1F3F, "R10");
        reg_wr(12'h608, 64'h0101, "R10");
        reg_rd(12'h400, "R10");
        reg_rd(12'h008, "R10");
        compare_posts("R10", 1'b0);

        // random traffic on mapped registers
        for (int k = 0; k < 250; k++) begin
            logic [2:0]  idx;
            logic [63:0] d;
            idx = 3'($urandom_range(0, NSRC-1));
            d = {$urandom, $urandom};
            case ($urandom_range(0, 4))
                0: reg_wr({6'd0, idx, 3'd0}, d, "R2");
                1: reg_wr({3'd1, 3'd0, idx, 3'd0}, d & 64'h6, "R3");
                2: fire(NSRC'($urandom), "R6");
                3: reg_rd({2'd0, 1'($urandom), 3'd0, idx, 3'd0}, "R3");
                default: dispatch(2'($urandom), 5'($urandom), 6'($urandom), "R7");
            endcase
        end
        compare_posts("R5", 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule